// File: doc/BRIEF.md
# Per-Context Priority Threshold Arbiter

This block picks, for one interrupt target context, the source that should be presented to that context next. It sees the state of every source as bit vectors (pending, claimed, enabled for this context), one priority value per source, and the context's threshold. Each cycle it chooses the eligible source with the highest priority that is strictly above the threshold, breaking ties toward the smaller identifier. The chosen identifier and a request line are registered, so they follow the inputs one clock later.

Identifier zero is reserved and means "nothing to take". A register block elsewhere owns the pending capture, the claim and completion side effects and software access. It feeds this arbiter and reads back the identifier when the context claims. One arbiter is instantiated per context. The number of identifier slots and the priority width are parameters. A build-time switch selects where the threshold test sits: at the root of the comparison tree, or at every leaf.

Top module: `ctx_prio_arbiter`

## Requirements
- R1: A source is a candidate only when its pending bit is 1, its claimed bit is 0 and its enable bit is 1. A claimed or disabled source is never selected.
- R2: A candidate can be selected only if its priority is strictly greater than `thresh`. A priority equal to the threshold never wins.
- R3: Among candidates sharing the highest priority, the smallest identifier is selected.
- R4: `win_id` is 0 when no candidate has a priority above `thresh`.
- R5: `irq_req` is 1 exactly when `win_id` is nonzero.
- R6: Outputs are registered. The values present at the inputs at a rising clock edge appear on `win_id` and `irq_req` after that edge and hold until the next one.
- R7: While `rst` is high at a rising edge, `win_id` and `irq_req` are cleared to 0 at that edge.
- R8: Identifier n maps to bit n of each flat vector, so bit b of 32-bit word w is identifier 32*w+b. Its priority occupies bits [n*PRIO_W +: PRIO_W] of `prio_flat`. Bit 0 and bits at or above NUM_ID are ignored and are never selected.
- R9: A source with priority 0 is never selected.
- R10: The candidate with the highest priority is selected wherever it sits in the vectors.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pend_vec | input | WORDS*32 | Pending bit per identifier |
| claim_vec | input | WORDS*32 | Claimed bit per identifier |
| en_vec | input | WORDS*32 | Enable bit per identifier for this context |
| prio_flat | input | NUM_ID*PRIO_W | Priority per identifier, packed |
| thresh | input | PRIO_W | Context threshold |
| win_id | output | ID_W | Selected identifier, 0 for none |
| irq_req | output | 1 | Interrupt request to the context |

## Verification
On every cycle, the checker confirms four things against the inputs it captured at the previous edge: a nonzero result names a real source, that source was a candidate, and its priority beat both the threshold and zero. It also checks that the request line agrees with the identifier and that reset clears both outputs. These checks cannot show that the winner was the best choice. Highest-priority selection and lowest-identifier tie breaking are shown only by the bench's scenarios: its table rows with equal priorities, threshold boundaries and masked winners, and its random vectors compared against a sequential scan model.

// File: rtl/ctx_arb_pkg.sv
package ctx_arb_pkg;

  // number of 32-bit words needed to hold n identifier bits
  function automatic int words_for(input int n);
    return (n + 31) / 32;
  endfunction

  // power-of-two leaf count for a comparison tree over n inputs
  function automatic int leaves_for(input int n);
    int l;
    l = 2;
    while (l < n) l = l * 2;
    return l;
  endfunction

endpackage

// File: rtl/src_eligible.sv
module src_eligible #(
  parameter int NUM_ID = 48,
  parameter int VEC_W  = 64
) (
  input  logic [VEC_W-1:0] pend_vec,
  input  logic [VEC_W-1:0] claim_vec,
  input  logic [VEC_W-1:0] en_vec,
  output logic [VEC_W-1:0] elig
);

  localparam int WORDS = VEC_W / 32;

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    for (genvar b = 0; b < 32; b++) begin : g_bit
      localparam int ID = w * 32 + b;
      // slot 0 is reserved and slots past NUM_ID do not exist
      localparam bit KEEP = (ID != 0) && (ID < NUM_ID);
      assign elig[ID] = KEEP & pend_vec[ID] & ~claim_vec[ID] & en_vec[ID];
    end
  end

endmodule

// File: rtl/prio_tree.sv
module prio_tree #(
  parameter int LEAVES      = 64,
  parameter int PRIO_W      = 3,
  parameter bit THR_AT_LEAF = 1'b0,
  localparam int ID_W       = $clog2(LEAVES)
) (
  input  logic [LEAVES-1:0]        leaf_vld,
  input  logic [LEAVES*PRIO_W-1:0] leaf_prio,
  input  logic [PRIO_W-1:0]        thresh,
  output logic [ID_W-1:0]          best_id,
  output logic                     hit
);

  localparam int NODES = 2 * LEAVES;

  // heap layout: node 1 is the root, node LEAVES+i is leaf i
  logic              nv [1:NODES-1];
  logic [PRIO_W-1:0] np [1:NODES-1];
  logic [ID_W-1:0]   ni [1:NODES-1];

  for (genvar i = 0; i < LEAVES; i++) begin : g_leaf
    logic [PRIO_W-1:0] p;
    assign p = leaf_prio[i*PRIO_W +: PRIO_W];
    if (THR_AT_LEAF) begin : g_filt
      assign nv[LEAVES+i] = leaf_vld[i] && (p > thresh);
    end else begin : g_raw
      assign nv[LEAVES+i] = leaf_vld[i];
    end
    assign np[LEAVES+i] = p;
    assign ni[LEAVES+i] = ID_W'(i);
  end

  for (genvar k = 1; k < LEAVES; k++) begin : g_node
    logic take_r;
    // the lower-index side keeps ties, matching an ascending strict scan
    assign take_r = nv[2*k+1] && (!nv[2*k] || (np[2*k+1] > np[2*k]));
    assign nv[k]  = nv[2*k] | nv[2*k+1];
    assign np[k]  = take_r ? np[2*k+1] : np[2*k];
    assign ni[k]  = take_r ? ni[2*k+1] : ni[2*k];
  end

  if (THR_AT_LEAF) begin : g_root_leaf
    logic [PRIO_W-1:0] root_p_unused;
    assign root_p_unused = np[1];
    assign hit = nv[1];
  end else begin : g_root_cmp
    assign hit = nv[1] && (np[1] > thresh);
  end
  assign best_id = ni[1];

endmodule

// File: rtl/ctx_prio_arbiter.sv
module ctx_prio_arbiter #(
  parameter int  NUM_ID      = 48,
  parameter int  PRIO_W      = 3,
  parameter bit  THR_AT_LEAF = 1'b0,
  localparam int WORDS       = ctx_arb_pkg::words_for(NUM_ID),
  localparam int VEC_W       = WORDS * 32,
  localparam int LEAVES      = ctx_arb_pkg::leaves_for(VEC_W),
  localparam int ID_W        = $clog2(LEAVES)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [VEC_W-1:0]         pend_vec,
  input  logic [VEC_W-1:0]         claim_vec,
  input  logic [VEC_W-1:0]         en_vec,
  input  logic [NUM_ID*PRIO_W-1:0] prio_flat,
  input  logic [PRIO_W-1:0]        thresh,
  output logic [ID_W-1:0]          win_id,
  output logic                     irq_req
);

  logic [VEC_W-1:0]         elig;
  logic [LEAVES-1:0]        leaf_vld;
  logic [LEAVES*PRIO_W-1:0] leaf_prio;
  logic [ID_W-1:0]          best_id;
  logic                     hit;

  src_eligible #(.NUM_ID(NUM_ID), .VEC_W(VEC_W)) elig_i (
    .pend_vec (pend_vec),
    .claim_vec(claim_vec),
    .en_vec   (en_vec),
    .elig     (elig)
  );

  for (genvar i = 0; i < LEAVES; i++) begin : g_map
    if (i < VEC_W) begin : g_v
      assign leaf_vld[i] = elig[i];
    end else begin : g_vpad
      assign leaf_vld[i] = 1'b0;
    end
    if (i < NUM_ID) begin : g_p
      assign leaf_prio[i*PRIO_W +: PRIO_W] = prio_flat[i*PRIO_W +: PRIO_W];
    end else begin : g_ppad
      assign leaf_prio[i*PRIO_W +: PRIO_W] = '0;
    end
  end

  prio_tree #(.LEAVES(LEAVES), .PRIO_W(PRIO_W), .THR_AT_LEAF(THR_AT_LEAF)) tree_i (
    .leaf_vld (leaf_vld),
    .leaf_prio(leaf_prio),
    .thresh   (thresh),
    .best_id  (best_id),
    .hit      (hit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      win_id  <= '0;
      irq_req <= 1'b0;
    end else begin
      win_id  <= hit ? best_id : '0;
      irq_req <= hit;
    end
  end

endmodule

// File: rtl/ctx_prio_arbiter_chk.sv
module ctx_prio_arbiter_chk #(
  parameter int  NUM_ID = 48,
  parameter int  PRIO_W = 3,
  localparam int WORDS  = ctx_arb_pkg::words_for(NUM_ID),
  localparam int VEC_W  = WORDS * 32,
  localparam int LEAVES = ctx_arb_pkg::leaves_for(VEC_W),
  localparam int ID_W   = $clog2(LEAVES)
) (
  input logic                     clk,
  input logic                     rst,
  input logic [VEC_W-1:0]         pend_vec,
  input logic [VEC_W-1:0]         claim_vec,
  input logic [VEC_W-1:0]         en_vec,
  input logic [NUM_ID*PRIO_W-1:0] prio_flat,
  input logic [PRIO_W-1:0]        thresh,
  input logic [ID_W-1:0]          win_id,
  input logic                     irq_req
);

  logic [VEC_W-1:0]         cand_q;
  logic [NUM_ID*PRIO_W-1:0] prio_q;
  logic [PRIO_W-1:0]        thr_q;
  logic [PRIO_W-1:0]        win_prio;
  logic                     win_cand;

  always_ff @(posedge clk) begin
    cand_q <= pend_vec & ~claim_vec & en_vec;
    prio_q <= prio_flat;
    thr_q  <= thresh;
  end

  always_comb begin
    win_prio = '0;
    win_cand = 1'b0;
    if (32'(win_id) < NUM_ID) begin
      win_prio = prio_q[32'(win_id)*PRIO_W +: PRIO_W];
      win_cand = cand_q[win_id];
    end
  end

  // R5
  req_matches_id_chk: assert property (@(posedge clk) disable iff (rst)
    irq_req == (win_id != '0));

  // R8
  id_in_range_chk: assert property (@(posedge clk) disable iff (rst)
    32'(win_id) < NUM_ID);

  // R1
  winner_was_candidate_chk: assert property (@(posedge clk) disable iff (rst)
    (win_id != '0) |-> win_cand);

  // R2
  winner_above_thresh_chk: assert property (@(posedge clk) disable iff (rst)
    (win_id != '0) |-> (win_prio > thr_q));

  // R9
  winner_prio_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
    (win_id != '0) |-> (win_prio != '0));

  // R4
  idle_when_no_cand_chk: assert property (@(posedge clk) disable iff (rst)
    (cand_q == '0) |-> (win_id == '0));

  // R7
  reset_clears_chk: assert property (@(posedge clk)
    $past(rst) |-> (win_id == '0 && !irq_req));

endmodule

bind ctx_prio_arbiter ctx_prio_arbiter_chk #(.NUM_ID(NUM_ID), .PRIO_W(PRIO_W)) chk_i (.*);

// File: tb/ctx_prio_arbiter_tb_top.sv
`timescale 1ns/1ps
module ctx_prio_arbiter_tb_top;

  localparam int NUM_ID = 48;
  localparam int PRIO_W = 3;
  localparam int VEC_W  = 64;
  localparam int ID_W   = 6;
  localparam int NROWS  = 16;

  logic                     clk = 1'b0;
  logic                     rst = 1'b1;
  logic [VEC_W-1:0]         pend_vec = '0;
  logic [VEC_W-1:0]         claim_vec = '0;
  logic [VEC_W-1:0]         en_vec = '0;
  logic [NUM_ID*PRIO_W-1:0] prio_flat = '0;
  logic [PRIO_W-1:0]        thresh = '0;
  logic [ID_W-1:0]          win_id;
  logic                     irq_req;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  ctx_prio_arbiter #(.NUM_ID(NUM_ID), .PRIO_W(PRIO_W)) dut_i (
    .clk(clk), .rst(rst), .pend_vec(pend_vec), .claim_vec(claim_vec),
    .en_vec(en_vec), .prio_flat(prio_flat), .thresh(thresh),
    .win_id(win_id), .irq_req(irq_req)
  );

  typedef struct packed {
    logic [63:0] pend;
    logic [63:0] claim;
    logic [63:0] en;
    logic [2:0]  thr;
    logic [1:0]  mode;   // 0: all 3, 1: id%8, 2: 7-id%8
    logic [5:0]  exp;
  } row_t;

  localparam logic [63:0] ONES = '1;

  localparam row_t TBL [NROWS] = '{
    '{64'h0,                  64'h0, ONES,                  3'd0, 2'd0, 6'd0 },  // R4 nothing pending
    '{ONES,                   64'h0, ONES,                  3'd0, 2'd0, 6'd1 },  // R3 all equal
    '{ONES,                   64'h0, ONES,                  3'd3, 2'd0, 6'd0 },  // R2 equal to thresh
    '{ONES,                   64'h0, ONES,                  3'd2, 2'd0, 6'd1 },  // R2 one above
    '{ONES,                   64'h0, ONES,                  3'd0, 2'd1, 6'd7 },  // R10
    '{ONES,                   64'h80, ONES,                 3'd0, 2'd1, 6'd15},  // R1 claimed
    '{ONES,                   64'h0, ~64'h8080,             3'd0, 2'd1, 6'd23},  // R1 disabled
    '{64'h7E,                 64'h0, ONES,                  3'd0, 2'd1, 6'd6 },  // R10
    '{64'h7E,                 64'h0, ONES,                  3'd6, 2'd1, 6'd0 },  // R4
    '{64'h100,                64'h0, ONES,                  3'd0, 2'd1, 6'd0 },  // R9
    '{ONES,                   64'h0, ONES,                  3'd0, 2'd2, 6'd8 },  // R8 slot 0
    '{64'hFFFF_0000_0000_0000, 64'h0, ONES,                 3'd0, 2'd0, 6'd0 },  // R8 high slots
    '{64'h1,                  64'h0, ONES,                  3'd0, 2'd0, 6'd0 },  // R8 slot 0 only
    '{64'h0000_8000_0000_0000, 64'h0, ONES,                 3'd0, 2'd0, 6'd47},  // R8 top slot
    '{64'h0000_0102_0000_0000, 64'h0, ONES,                 3'd0, 2'd2, 6'd40},  // R10
    '{ONES,                   ~64'hC000_0000, ONES,         3'd0, 2'd2, 6'd30}   // R1 R9
  };

  function automatic string row_tag(input int r);
    case (r)
      0, 8:        return "R4";
      1:           return "R3";
      2, 3:        return "R2";
      4, 7, 14:    return "R10";
      5, 6, 15:    return "R1";
      9:           return "R9";
      default:     return "R8";
    endcase
  endfunction

  function automatic logic [NUM_ID*PRIO_W-1:0] mk_prio(input int mode);
    logic [NUM_ID*PRIO_W-1:0] v;
    v = '0;
    for (int i = 0; i < NUM_ID; i++) begin
      case (mode)
        0:       v[i*PRIO_W +: PRIO_W] = 3'd3;
        1:       v[i*PRIO_W +: PRIO_W] = 3'(i % 8);
        default: v[i*PRIO_W +: PRIO_W] = 3'(7 - (i % 8));
      endcase
    end
    return v;
  endfunction

  // sequential scan model from the requirements
  function automatic int ref_pick(input logic [63:0] p, input logic [63:0] c,
                                  input logic [63:0] e,
                                  input logic [NUM_ID*PRIO_W-1:0] pr,
                                  input logic [PRIO_W-1:0] t);
    int best;
    int mx;
    best = 0;
    mx   = int'(t);
    for (int i = 1; i < NUM_ID; i++) begin
      if (p[i] && !c[i] && e[i] && int'(pr[i*PRIO_W +: PRIO_W]) > mx) begin
        best = i;
        mx   = int'(pr[i*PRIO_W +: PRIO_W]);
      end
    end
    return best;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 100000);
    n_chk++;
    n_fail++;
    $display("FAIL R6 watchdog actual=hung expected=complete");
    finish_run();
  end

  initial begin
    // R7: reset state
    repeat (3) @(negedge clk);
    check("R7 id in reset", int'(win_id), 0);
    check("R7 req in reset", int'(irq_req), 0);
    rst = 1'b0;

    // table walk
    for (int r = 0; r < NROWS; r++) begin
      @(negedge clk);
      pend_vec  = TBL[r].pend;
      claim_vec = TBL[r].claim;
      en_vec    = TBL[r].en;
      thresh    = TBL[r].thr;
      prio_flat = mk_prio(int'(TBL[r].mode));
      @(negedge clk);
      check(row_tag(r), int'(win_id), int'(TBL[r].exp));
      check(row_tag(r), ref_pick(pend_vec, claim_vec, en_vec, prio_flat, thresh),
            int'(TBL[r].exp));
      check("R5", int'(irq_req), int'(TBL[r].exp != 0));
    end

    // R6: one-cycle latency, held between edges
    @(negedge clk);
    pend_vec = 64'h10; claim_vec = '0; en_vec = ONES; thresh = 3'd0;
    prio_flat = mk_prio(0);
    #1;
    check("R6 before edge", int'(win_id), 30);
    @(posedge clk);
    #1;
    check("R6 after edge", int'(win_id), 4);
    pend_vec = 64'h20;
    #1;
    check("R6 held", int'(win_id), 4);
    @(negedge clk);
    @(negedge clk);
    check("R6 next edge", int'(win_id), 5);

    // R7: reset mid-run with a live candidate
    rst = 1'b1;
    @(negedge clk);
    check("R7 mid-run id", int'(win_id), 0);
    check("R7 mid-run req", int'(irq_req), 0);
    rst = 1'b0;
    @(negedge clk);
    check("R7 release", int'(win_id), 5);

    // random vectors against the scan model
    for (int n = 0; n < 300; n++) begin
      int e;
      @(negedge clk);
      pend_vec  = {$urandom(), $urandom()};
      claim_vec = {$urandom(), $urandom()} & {$urandom(), $urandom()};
      en_vec    = {$urandom(), $urandom()} | {$urandom(), $urandom()};
      thresh    = 3'($urandom_range(0, 7));
      if (n % 4 == 0) begin
        prio_flat = mk_prio(0);
        thresh    = 3'($urandom_range(2, 3));
      end else begin
        for (int i = 0; i < NUM_ID; i++)
          prio_flat[i*PRIO_W +: PRIO_W] = 3'($urandom_range(0, 7));
      end
      e = ref_pick(pend_vec, claim_vec, en_vec, prio_flat, thresh);
      @(negedge clk);
      check("R3 R10 random", int'(win_id), e);
      check("R5 random", int'(irq_req), int'(e != 0));
    end

    finish_run();
  end

endmodule